// File: doc/BRIEF.md
# Auxiliary Bus Mailbox Bridge

This block lets a host reach slow 8-bit peripherals on an auxiliary bus without mapping them into its own address space. The host writes one command word into a mailbox register. The word names the target device, a 3-bit register address inside that device, the transfer direction and, for a write, the data byte. The bridge accepts the word only when no cycle is in progress. It then runs a single strobed cycle on the auxiliary bus: the chip select and the address come first, then the read or write strobe. The strobe is stretched by the device's ready and wait-state inputs, and a timeout bounds it.

The host polls a status register. It shows a busy flag, a completion flag, a timeout error flag and the byte that was read. The bridge also gathers rising-edge interrupt requests from the peripherals into sticky status bits. The host clears these bits by writing ones to them. A per-bit enable mask gates the bits onto a single interrupt output.

All registers sit behind a synchronous port with a write strobe, a 2-bit register index, 16-bit write data and combinational read data. Index 0 is the command, 1 is the status, 2 is the interrupt status and 3 is the interrupt enable.

Top module: `aux_mailbox_bridge`

## Requirements
- R1: A write to index 0 while idle starts one bus cycle. Command bits [2:0] select the device, [5:3] give the register address, bit 6 is 1 for a read and 0 for a write, and bits [15:8] are the write data. During the cycle exactly one bit of `aux_cs_n` is low, the bit numbered by the device select. `aux_adr` carries the address. For a write, `aux_dout` carries the data while `aux_doe` is high.
- R2: The chip select and the address are asserted on the clock before the strobe goes low.
- R3: The strobe (`aux_rd_n` for a read, `aux_wr_n` for a write, never both) stays low for at least 2 clocks. It rises on the first edge, after at least one edge with the strobe low, at which `aux_rdy` is high and `aux_wait` is low. It is never low for more than 255 clocks.
- R4: On the edge that releases the strobe of a read, the value on `aux_din` is latched into status bits [15:8].
- R5: Status bit 0 (busy) is set when a command is accepted and cleared when the strobe is released. Status bit 1 (done) is cleared on acceptance and set on release.
- R6: A command write while busy is ignored. No further bus cycle follows, and the running cycle keeps its device, address and data.
- R7: If the strobe has been low for 255 clocks without a completion condition, the cycle ends anyway and status bit 2 (timeout) is set. That bit is cleared when the next command is accepted.
- R8: A rising edge on `aux_irq[i]` sets bit i of the interrupt status register (index 2). Writing 1 to that bit clears it. A level held high does not set it again.
- R9: `irq_o` is high exactly when some interrupt status bit and the matching bit of the enable register (index 3) are both set.
- R10: After reset all chip selects and strobes are high, and the status, interrupt status, enable and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |
| aux_cs_n | output | 8 | Device selects, active low |
| aux_adr | output | 3 | Device register address |
| aux_dout | output | 8 | Write data to the device |
| aux_doe | output | 1 | High while `aux_dout` should be driven |
| aux_din | input | 8 | Read data from the device |
| aux_rd_n | output | 1 | Read strobe, active low |
| aux_wr_n | output | 1 | Write strobe, active low |
| aux_rdy | input | 1 | Device ready, active high |
| aux_wait | input | 1 | Wait-state request, active high |
| aux_irq | input | 2 | Interrupt requests, rising edge |
| irq_o | output | 1 | Combined, enabled interrupt |

## Verification
Random reads and writes run against a modelled peripheral. Each transfer draws a device, an address, a ready latency and a wait-state length, so the measured strobe width shows whether the minimum width, the ready input or the wait input decides the end of the cycle. Separate directed cases cover the rest:
- A ready latency far above the limit tells a timeout apart from a slow completion.
- A command written during a cycle shows that it is dropped rather than queued.
- Interrupt pulses, held levels and write-one-to-clear writes, with and without the enable mask, tell edge capture from level capture and show the gating on `irq_o`.

// File: rtl/aux_mbx_pkg.sv
package aux_mbx_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_SETUP  = 2'd1,
    CYC_STROBE = 2'd2
  } cyc_state_t;

  localparam logic [1:0] IDX_CMD  = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_IRQ  = 2'd2;
  localparam logic [1:0] IDX_IEN  = 2'd3;

  localparam int HOST_W = 16;
endpackage

// File: rtl/aux_cycle_engine.sv
module aux_cycle_engine
  import aux_mbx_pkg::*;
#(
  parameter int N_CS    = 8,
  parameter int ADR_W   = 3,
  parameter int DAT_W   = 8,
  parameter int TMO     = 255,
  parameter int MIN_STB = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [$clog2(N_CS)-1:0]  sel_in,
  input  logic [ADR_W-1:0]         adr_in,
  input  logic                     rnw_in,
  input  logic [DAT_W-1:0]         wdat_in,
  input  logic                     rdy,
  input  logic                     wt,
  input  logic [DAT_W-1:0]         din,
  output logic [N_CS-1:0]          cs_n,
  output logic [ADR_W-1:0]         adr,
  output logic [DAT_W-1:0]         dout,
  output logic                     doe,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     busy,
  output logic                     fin,
  output logic                     tmo_hit,
  output logic [DAT_W-1:0]         rdat
);
  localparam int SEL_W = $clog2(N_CS);
  localparam int CNT_W = $clog2(TMO + 1);

  cyc_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [ADR_W-1:0]  adr_q, adr_d;
  logic              rnw_q, rnw_d;
  logic [DAT_W-1:0]  wdat_q, wdat_d;
  logic [DAT_W-1:0]  rdat_q, rdat_d;
  logic              active;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    adr_d   = adr_q;
    rnw_d   = rnw_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    fin     = 1'b0;
    tmo_hit = 1'b0;
    case (state_q)
      CYC_IDLE: begin
        if (start) begin
          sel_d   = sel_in;
          adr_d   = adr_in;
          rnw_d   = rnw_in;
          wdat_d  = wdat_in;
          state_d = CYC_SETUP;
        end
      end
      CYC_SETUP: begin
        cnt_d   = '0;
        state_d = CYC_STROBE;
      end
      CYC_STROBE: begin
        if (cnt_q >= CNT_W'(MIN_STB - 1) && rdy && !wt) begin
          fin     = 1'b1;
          rdat_d  = din;
          state_d = CYC_IDLE;
        end else if (cnt_q == CNT_W'(TMO - 1)) begin
          fin     = 1'b1;
          tmo_hit = 1'b1;
          rdat_d  = din;
          state_d = CYC_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
      adr_q   <= '0;
      rnw_q   <= 1'b0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      adr_q   <= adr_d;
      rnw_q   <= rnw_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
    end
  end

  assign active = (state_q != CYC_IDLE);

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign cs_n[g] = !(active && (sel_q == SEL_W'(g)));
  end

  assign adr  = adr_q;
  assign dout = wdat_q;
  assign doe  = active && !rnw_q;
  assign rd_n = !((state_q == CYC_STROBE) && rnw_q);
  assign wr_n = !((state_q == CYC_STROBE) && !rnw_q);
  assign busy = active;
  assign rdat = rdat_q;
endmodule

// File: rtl/aux_irq_collect.sv
module aux_irq_collect #(
  parameter int N_IRQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             clr_we,
  input  logic [N_IRQ-1:0] clr_mask,
  input  logic             en_we,
  input  logic [N_IRQ-1:0] en_val,
  output logic [N_IRQ-1:0] stat,
  output logic [N_IRQ-1:0] en,
  output logic             irq_o
);
  logic [N_IRQ-1:0] prev_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic rise, stat_d, stat_ce;
    assign rise    = irq_in[i] && !prev_q[i];
    assign stat_ce = rise || (clr_we && clr_mask[i]);
    assign stat_d  = rise;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        stat[i]   <= 1'b0;
        en[i]     <= 1'b0;
      end else begin
        prev_q[i] <= irq_in[i];
        if (stat_ce) stat[i] <= stat_d;
        if (en_we)   en[i]   <= en_val[i];
      end
    end
  end

  assign irq_o = |(stat & en);
endmodule

// File: rtl/aux_mailbox_bridge.sv
module aux_mailbox_bridge
  import aux_mbx_pkg::*;
#(
  parameter int N_CS  = 8,
  parameter int ADR_W = 3,
  parameter int DAT_W = 8,
  parameter int N_IRQ = 2,
  parameter int TMO   = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic [N_CS-1:0]   aux_cs_n,
  output logic [ADR_W-1:0]  aux_adr,
  output logic [DAT_W-1:0]  aux_dout,
  output logic              aux_doe,
  input  logic [DAT_W-1:0]  aux_din,
  output logic              aux_rd_n,
  output logic              aux_wr_n,
  input  logic              aux_rdy,
  input  logic              aux_wait,
  input  logic [N_IRQ-1:0]  aux_irq,
  output logic              irq_o
);
  localparam int SEL_W   = $clog2(N_CS);
  localparam int ADR_LSB = SEL_W;
  localparam int RNW_BIT = SEL_W + ADR_W;
  localparam int DAT_LSB = 8;

  logic             busy, fin, tmo_hit, accept;
  logic             done_q, done_d, err_q, err_d;
  logic [DAT_W-1:0] rdat;
  logic [N_IRQ-1:0] irq_stat, irq_en;

  assign accept = host_we && (host_addr == IDX_CMD) && !busy;

  aux_cycle_engine #(
    .N_CS(N_CS), .ADR_W(ADR_W), .DAT_W(DAT_W), .TMO(TMO), .MIN_STB(2)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .sel_in  (host_wdata[SEL_W-1:0]),
    .adr_in  (host_wdata[ADR_LSB +: ADR_W]),
    .rnw_in  (host_wdata[RNW_BIT]),
    .wdat_in (host_wdata[DAT_LSB +: DAT_W]),
    .rdy     (aux_rdy),
    .wt      (aux_wait),
    .din     (aux_din),
    .cs_n    (aux_cs_n),
    .adr     (aux_adr),
    .dout    (aux_dout),
    .doe     (aux_doe),
    .rd_n    (aux_rd_n),
    .wr_n    (aux_wr_n),
    .busy    (busy),
    .fin     (fin),
    .tmo_hit (tmo_hit),
    .rdat    (rdat)
  );

  aux_irq_collect #(.N_IRQ(N_IRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (aux_irq),
    .clr_we   (host_we && (host_addr == IDX_IRQ)),
    .clr_mask (host_wdata[N_IRQ-1:0]),
    .en_we    (host_we && (host_addr == IDX_IEN)),
    .en_val   (host_wdata[N_IRQ-1:0]),
    .stat     (irq_stat),
    .en       (irq_en),
    .irq_o    (irq_o)
  );

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    if (accept) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (fin) begin
      done_d = 1'b1;
      err_d  = tmo_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      IDX_STAT: begin
        host_rdata[0]                = busy;
        host_rdata[1]                = done_q;
        host_rdata[2]                = err_q;
        host_rdata[DAT_LSB +: DAT_W] = rdat;
      end
      IDX_IRQ: host_rdata[N_IRQ-1:0] = irq_stat;
      IDX_IEN: host_rdata[N_IRQ-1:0] = irq_en;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_mailbox_checks.sv
module aux_mailbox_checks #(
  parameter int N_CS  = 8,
  parameter int N_IRQ = 2,
  parameter int TMO   = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic [1:0]       host_addr,
  input logic [N_CS-1:0]  aux_cs_n,
  input logic             aux_rd_n,
  input logic             aux_wr_n,
  input logic             aux_rdy,
  input logic             aux_wait,
  input logic [N_IRQ-1:0] aux_irq,
  input logic [N_IRQ-1:0] irq_stat
);
  localparam int LC_W = $clog2(TMO + 1) + 1;

  logic            stb_n;
  logic [LC_W-1:0] lowcnt;

  assign stb_n = aux_rd_n && aux_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lowcnt <= '0;
    else if (!stb_n) lowcnt <= lowcnt + 1'b1;
    else             lowcnt <= '0;
  end

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~aux_cs_n));

  assert_cs_during_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n |-> ($countones(~aux_cs_n) == 1));

  assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_n) |-> ($past(aux_cs_n) != '1));

  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!aux_rd_n && !aux_wr_n));

  assert_strobe_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_n) |=> !stb_n);

  assert_release_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_n) |-> (($past(aux_rdy) && !$past(aux_wait)) || (lowcnt == LC_W'(TMO))));

  assert_strobe_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lowcnt <= LC_W'(TMO));

  assert_busy_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 2'd0 && aux_cs_n != '1) |=>
      (aux_cs_n == $past(aux_cs_n) || aux_cs_n == '1));

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq_chk
    assert_irq_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aux_irq[i]) |=> irq_stat[i]);
  end
endmodule

bind aux_mailbox_bridge aux_mailbox_checks #(
  .N_CS(N_CS), .N_IRQ(N_IRQ), .TMO(TMO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_addr (host_addr),
  .aux_cs_n  (aux_cs_n),
  .aux_rd_n  (aux_rd_n),
  .aux_wr_n  (aux_wr_n),
  .aux_rdy   (aux_rdy),
  .aux_wait  (aux_wait),
  .aux_irq   (aux_irq),
  .irq_stat  (irq_stat)
);

// File: tb/sim_aux_mailbox_bridge.sv
module sim_aux_mailbox_bridge;
  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic [1:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [7:0]  aux_cs_n;
  logic [2:0]  aux_adr;
  logic [7:0]  aux_dout;
  logic        aux_doe;
  logic [7:0]  aux_din;
  logic        aux_rd_n, aux_wr_n, aux_rdy, aux_wait;
  logic [1:0]  aux_irq;
  logic        irq_o;

  int n_chk, n_fail;
  int lat, wlen, sc;
  int n_cyc, last_width;
  logic [7:0] cap_cs, prev_cs, cap_dout;
  logic [2:0] cap_adr;
  logic       cap_doe, cap_rnw, cap_setup_ok;
  logic [7:0] dev_mem [8][8];
  logic [7:0] exp_mem [8][8];
  bit         finished;

  aux_mailbox_bridge u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int cs_index(logic [7:0] csn);
    int idx = 0;
    for (int i = 0; i < 8; i++) if (!csn[i]) idx = i;
    return idx;
  endfunction

  function automatic logic [7:0] exp_cs(int s);
    return ~(8'd1 << s);
  endfunction

  function automatic int exp_width(int l, int w);
    int r = 2;
    if (l + 1 > r) r = l + 1;
    if (w + 1 > r) r = w + 1;
    if (r > 255) r = 255;
    return r;
  endfunction

  assign aux_rdy  = (sc > lat);
  assign aux_wait = (sc <= wlen);
  always_comb aux_din = !aux_rd_n ? dev_mem[cs_index(aux_cs_n)][aux_adr] : 8'h00;

  // peripheral model and bus monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      sc = 0;
    end else if (!(aux_rd_n && aux_wr_n)) begin
      if (sc == 0) begin
        cap_cs       = aux_cs_n;
        cap_adr      = aux_adr;
        cap_dout     = aux_dout;
        cap_doe      = aux_doe;
        cap_rnw      = !aux_rd_n;
        cap_setup_ok = (prev_cs == aux_cs_n);
      end
      sc = sc + 1;
    end else if (sc != 0) begin
      last_width = sc;
      n_cyc      = n_cyc + 1;
      if (!cap_rnw) dev_mem[cs_index(cap_cs)][cap_adr] = cap_dout;
      sc = 0;
    end
    prev_cs = aux_cs_n;
  end

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic host_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(logic [1:0] a, output logic [15:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(output logic [15:0] st);
    int guard = 0;
    host_read(2'd1, st);
    while (st[0] && guard < 400) begin
      @(negedge clk);
      host_read(2'd1, st);
      guard++;
    end
  endtask

  task automatic run_cmd(int s, int a, bit rnw, logic [7:0] wd, int l, int w);
    logic [15:0] st;
    int c0 = n_cyc;
    bit tmo = (exp_width(l, w) == 255) && (l + 1 >= 255 || w + 1 >= 255) && !(l + 1 == 255 && w + 1 <= 255);
    lat = l; wlen = w;
    host_write(2'd0, {wd, 1'b0, rnw, 3'(a), 3'(s)});
    host_read(2'd1, st);
    check("R5 busy after accept", int'(st[1:0]), 1);
    wait_idle(st);
    check("R1 one cycle", n_cyc - c0, 1);
    check("R1 chip select", int'(cap_cs), int'(exp_cs(s)));
    check("R1 address", int'(cap_adr), a);
    check("R2 select before strobe", int'(cap_setup_ok), 1);
    check("R3 strobe width", last_width, exp_width(l, w));
    check("R5 done no busy", int'(st[1:0]), 2);
    check("R7 timeout flag", int'(st[2]), int'(tmo));
    if (!rnw) begin
      check("R1 write data", int'(cap_dout), int'(wd));
      check("R1 data enable", int'(cap_doe), 1);
      exp_mem[s][a] = wd;
    end else begin
      check("R1 no data enable", int'(cap_doe), 0);
      if (!tmo) check("R4 read data", int'(st[15:8]), int'(exp_mem[s][a]));
    end
    lat = 0; wlen = 0;
  endtask

  initial begin
    logic [15:0] st;
    int c0;
    n_chk = 0; n_fail = 0; n_cyc = 0; last_width = 0; sc = 0;
    lat = 0; wlen = 0; finished = 0;
    prev_cs = 8'hff; cap_cs = 8'hff; cap_adr = 0; cap_dout = 0;
    cap_doe = 0; cap_rnw = 0; cap_setup_ok = 0;
    host_we = 0; host_addr = 0; host_wdata = 0; aux_irq = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        dev_mem[i][j] = 8'(i * 16 + j * 3 + 1);
        exp_mem[i][j] = 8'(i * 16 + j * 3 + 1);
      end
    void'($urandom(32'd2024));
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    check("R10 cs idle", int'(aux_cs_n), 8'hff);
    check("R10 strobes idle", int'({aux_rd_n, aux_wr_n}), 3);
    host_read(2'd1, st); check("R10 status", int'(st), 0);
    host_read(2'd2, st); check("R10 irq status", int'(st), 0);
    host_read(2'd3, st); check("R10 irq enable", int'(st), 0);
    check("R10 irq out", int'(irq_o), 0);

    // directed: minimum width, ready-limited, wait-limited
    run_cmd(3, 5, 1'b0, 8'h5a, 0, 0);
    run_cmd(3, 5, 1'b1, 8'h00, 0, 0);
    run_cmd(0, 7, 1'b1, 8'h00, 6, 1);
    run_cmd(7, 0, 1'b0, 8'hc3, 1, 8);
    run_cmd(7, 0, 1'b1, 8'h00, 4, 4);

    // random transfers
    for (int k = 0; k < 40; k++) begin
      int s = $urandom_range(0, 7);
      int a = $urandom_range(0, 7);
      bit r = 1'($urandom_range(0, 1));
      logic [7:0] d = 8'($urandom);
      run_cmd(s, a, r, d, $urandom_range(0, 6), $urandom_range(0, 4));
    end

    // R7 timeout, then next accept clears the flag
    run_cmd(2, 1, 1'b1, 8'h00, 400, 0);
    run_cmd(2, 1, 1'b0, 8'h11, 0, 0);

    // R6 command while busy is dropped
    c0 = n_cyc;
    lat = 5;
    host_write(2'd0, {8'h77, 1'b0, 1'b0, 3'd2, 3'd4});
    host_write(2'd0, {8'h99, 1'b0, 1'b0, 3'd6, 3'd1});
    wait_idle(st);
    repeat (10) @(negedge clk);
    check("R6 single cycle", n_cyc - c0, 1);
    check("R6 first select kept", int'(cap_cs), int'(exp_cs(4)));
    check("R6 first data kept", int'(cap_dout), 8'h77);
    exp_mem[4][2] = 8'h77;
    lat = 0;

    // R8 / R9 interrupts
    @(negedge clk); aux_irq = 2'b01;
    @(negedge clk); aux_irq = 2'b00;
    @(negedge clk);
    host_read(2'd2, st); check("R8 edge captured", int'(st[1:0]), 1);
    check("R9 masked", int'(irq_o), 0);
    host_write(2'd3, 16'h0001);
    #1 check("R9 enabled", int'(irq_o), 1);
    host_write(2'd2, 16'h0001);
    host_read(2'd2, st); check("R8 cleared", int'(st[1:0]), 0);
    check("R9 low after clear", int'(irq_o), 0);
    aux_irq = 2'b10;
    repeat (3) @(negedge clk);
    host_read(2'd2, st); check("R8 second line", int'(st[1:0]), 2);
    check("R9 other line masked", int'(irq_o), 0);
    host_write(2'd2, 16'h0002);
    repeat (3) @(negedge clk);
    host_read(2'd2, st); check("R8 held level no reset", int'(st[1:0]), 0);
    host_write(2'd3, 16'h0003);
    aux_irq = 2'b00;
    @(negedge clk); aux_irq = 2'b10;
    repeat (2) @(negedge clk);
    check("R9 both enabled", int'(irq_o), 1);
    aux_irq = 2'b00;

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule